// File: doc/BRIEF.md
# Debug Breakpoint Status and Control Register

This block is the 32-bit control and status word of a processor debug unit. It follows a two-level hardware breakpoint through its arm and trigger stages and exposes that progress as a 4-bit status code. It records, in sticky flags, why the core entered debug mode. It also holds the control bits that decide how the external breakpoint pin behaves, whether the trace port runs, whether the core may write the debug registers, and how emulator mode is entered.

The breakpoint comparators report level hits and trigger-definition writes on plain strobes. The core reports debug-entry causes and instruction-boundary sample points. A GO command from the external host clears the resumable halt causes. The external breakpoint pin is active low. It either requests a halt directly, or, in edge mode, raises a one-cycle debug interrupt request that stays pending until the next sample point. The register port is a single-cycle read/write port with no back-pressure. Every access completes in the cycle it is presented, and a flag marks whether the external host or the core issued it.

Top module: `dbg_csr`

## Requirements
- R1: The status code is bits 31:28. After a trigger-definition write it reads 0001 ("waiting for level 1") if that write enabled level 1, and 0000 ("nothing enabled") otherwise. The other defined codes are 0010 (level 1 hit), 0101 (waiting for level 2) and 0110 (level 2 hit).
- R2: A level-1 hit while waiting for level 1 moves the code to 0101 if level 2 was enabled, and to 0010 if it was not. A level-2 hit while at 0101 moves it to 0110. Hits in any other state change nothing.
- R3: A register read that returns 0110, or returns 0010 with level 2 disabled, clears the code to 0000 from the next cycle. The read itself returns the value before the clear. Reads in other states change nothing. A trigger-definition write in the same cycle as such a read takes precedence.
- R4: Bits 27, 26, 25 and 24 are sticky flags for fault-on-fault, hardware trigger, halt instruction and breakpoint pin. Each is set one cycle after its event. The fault-on-fault flag is cleared only by reset.
- R5: A GO command clears bits 26:24 in the next cycle. A cause event that arrives in the same cycle as GO still sets its flag.
- R6: Bits 23:20 always read 0010. Bit 19 and bits 12:0 read 0. Writes never alter bits 31:19 or 12:0.
- R7: With bit 18 clear, a low level on the breakpoint pin drives bkpt_halt_req high two clock edges after the pin falls, and sets bit 24 one edge later.
- R8: With bit 18 set, a high-to-low transition on the pin raises dbg_irq for exactly one cycle, three edges after the pin falls. The request is held on dbg_irq_pend until the cycle after an inst_boundary pulse, and neither bkpt_halt_req nor bit 24 responds to the pin.
- R9: Falling edges that arrive while dbg_irq_pend is high are dropped and raise no request.
- R10: With bit 17 set, trace_clk_en and trace_valid_out stay low. With bit 17 clear, trace_clk_en is high and trace_valid_out follows trace_valid_in.
- R11: While bit 16 is set, core-issued writes (csr_host low) are ignored. Bit 16 itself changes only on host writes.
- R12: Bits 15, 14 and 13 are read/write. They drive emu_map_space, emu_on_trace and emu_force respectively.
- R13: After reset the register reads 0x00200000 and every output is low except trace_clk_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (may clear status) |
| csr_host | input | 1 | 1 = access from external host, 0 = from core |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current register value |
| td_wr | input | 1 | Trigger-definition register write |
| td_l1_en | input | 1 | Level-1 enable carried by that write |
| td_l2_en | input | 1 | Level-2 enable carried by that write |
| bp_l1_hit | input | 1 | Level-1 breakpoint match |
| bp_l2_hit | input | 1 | Level-2 breakpoint match |
| core_fof | input | 1 | Debug entry caused by fault-on-fault |
| core_trg | input | 1 | Debug entry caused by hardware trigger |
| core_halt | input | 1 | Debug entry caused by halt instruction |
| go_cmd | input | 1 | GO command strobe |
| bkpt_n | input | 1 | External breakpoint pin, active low, asynchronous |
| inst_boundary | input | 1 | Instruction-boundary interrupt sample point |
| trace_valid_in | input | 1 | Trace data valid from trace logic |
| bkpt_halt_req | output | 1 | Halt request from breakpoint pin (level mode) |
| dbg_irq | output | 1 | One-cycle debug interrupt request |
| dbg_irq_pend | output | 1 | Debug interrupt pending |
| trace_clk_en | output | 1 | Trace clock enable |
| trace_valid_out | output | 1 | Gated trace data valid |
| emu_map_space | output | 1 | Map emulator references to special space |
| emu_on_trace | output | 1 | Enter emulator mode on trace exception |
| emu_force | output | 1 | Force emulator mode |

## Verification
Two pairs of functions can act in the same cycle. A GO command can coincide with a halt-cause event, and a status-clearing read can coincide with a trigger-definition write. The bench sweeps every combination of preset flags, same-cycle events and GO. It predicts each flag as "event OR (previous AND NOT GO)" and compares that with the read-back. It also drives a read of the 0110 code together with a level-1-enabling definition write, and expects 0001 rather than 0000.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;
  localparam int unsigned CSR_W     = 32;
  localparam int unsigned STAT_LSB  = 28;
  localparam int unsigned FLAG_LSB  = 24;
  localparam int unsigned REV_LSB   = 20;
  localparam int unsigned CTRL_LSB  = 13;
  localparam int unsigned CTRL_W    = 6;
  localparam logic [3:0]  REV_CODE  = 4'b0010;

  typedef enum logic [3:0] {
    BS_IDLE  = 4'b0000,
    BS_WAIT1 = 4'b0001,
    BS_HIT1  = 4'b0010,
    BS_WAIT2 = 4'b0101,
    BS_HIT2  = 4'b0110
  } bstat_e;

  // bit 18 down to bit 13
  typedef struct packed {
    logic edge_mode;
    logic trace_off;
    logic wr_lock;
    logic map_space;
    logic emu_trace;
    logic emu_force;
  } ctrl_t;

  // bit 27 down to bit 24
  typedef struct packed {
    logic fof;
    logic trg;
    logic hlt;
    logic pin;
  } flags_t;
endpackage

// File: rtl/dbg_bp_status.sv
module dbg_bp_status
  import dbg_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   td_wr,
  input  logic   td_l1_en,
  input  logic   td_l2_en,
  input  logic   l1_hit,
  input  logic   l2_hit,
  input  logic   csr_rd,
  output bstat_e status
);
  logic l2_armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= BS_IDLE;
      l2_armed <= 1'b0;
    end else if (td_wr) begin
      status   <= td_l1_en ? BS_WAIT1 : BS_IDLE;
      l2_armed <= td_l2_en;
    end else begin
      case (status)
        BS_WAIT1: if (l1_hit) status <= l2_armed ? BS_WAIT2 : BS_HIT1;
        BS_WAIT2: if (l2_hit) status <= BS_HIT2;
        BS_HIT1:  if (csr_rd && !l2_armed) status <= BS_IDLE;
        BS_HIT2:  if (csr_rd) status <= BS_IDLE;
        default:  status <= status;
      endcase
    end
  end

  AST_L2_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == BS_WAIT2 && l2_hit && !td_wr) |=> (status == BS_HIT2)); // R2
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status == BS_HIT2 && csr_rd && !td_wr) |=> (status == BS_IDLE)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status == BS_IDLE && !td_wr) |=> (status == BS_IDLE)); // R2
endmodule

// File: rtl/dbg_halt_flags.sv
module dbg_halt_flags
  import dbg_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_fof,
  input  logic   ev_trg,
  input  logic   ev_hlt,
  input  logic   ev_pin,
  input  logic   go,
  output flags_t flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.fof <= flags.fof | ev_fof;
      flags.trg <= ev_trg | (flags.trg & ~go);
      flags.hlt <= ev_hlt | (flags.hlt & ~go);
      flags.pin <= ev_pin | (flags.pin & ~go);
    end
  end

  AST_FOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags.fof |=> flags.fof); // R4
  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ev_trg && !ev_hlt && !ev_pin) |=> !(flags.trg || flags.hlt || flags.pin)); // R5
endmodule

// File: rtl/dbg_pin_irq.sv
module dbg_pin_irq #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic boundary,
  output logic pin_low,
  output logic irq_pulse,
  output logic irq_pend
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;
  logic [CHAIN-1:0] chain;
  logic             fall;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= pin_n;
  end

  for (genvar g = 1; g < CHAIN; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  assign pin_low = ~chain[SYNC_STAGES-1];
  assign fall    = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_pend  <= 1'b0;
    end else begin
      irq_pulse <= fall & edge_mode & ~irq_pend;
      if (irq_pend) begin
        if (boundary) irq_pend <= 1'b0;
      end else if (fall && edge_mode) begin
        irq_pend <= 1'b1;
      end
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R8
  AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !boundary) |=> !irq_pulse); // R9
  AST_PEND_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_pend); // R8
endmodule

// File: rtl/dbg_csr.sv
module dbg_csr
  import dbg_csr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic        csr_rd,
  input  logic        csr_host,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        td_wr,
  input  logic        td_l1_en,
  input  logic        td_l2_en,
  input  logic        bp_l1_hit,
  input  logic        bp_l2_hit,
  input  logic        core_fof,
  input  logic        core_trg,
  input  logic        core_halt,
  input  logic        go_cmd,
  input  logic        bkpt_n,
  input  logic        inst_boundary,
  input  logic        trace_valid_in,
  output logic        bkpt_halt_req,
  output logic        dbg_irq,
  output logic        dbg_irq_pend,
  output logic        trace_clk_en,
  output logic        trace_valid_out,
  output logic        emu_map_space,
  output logic        emu_on_trace,
  output logic        emu_force
);
  bstat_e status;
  flags_t flags;
  ctrl_t  ctrl;
  ctrl_t  ctrl_wv;
  ctrl_t  ctrl_nxt;
  logic   wr_take;
  logic   pin_low;
  logic   unused_wbits;

  assign unused_wbits = ^{csr_wdata[CSR_W-1:CTRL_LSB+CTRL_W], csr_wdata[CTRL_LSB-1:0]};

  dbg_bp_status i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .td_wr    (td_wr),
    .td_l1_en (td_l1_en),
    .td_l2_en (td_l2_en),
    .l1_hit   (bp_l1_hit),
    .l2_hit   (bp_l2_hit),
    .csr_rd   (csr_rd),
    .status   (status)
  );

  dbg_pin_irq #(.SYNC_STAGES(SYNC_STAGES)) i_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (bkpt_n),
    .edge_mode (ctrl.edge_mode),
    .boundary  (inst_boundary),
    .pin_low   (pin_low),
    .irq_pulse (dbg_irq),
    .irq_pend  (dbg_irq_pend)
  );

  assign bkpt_halt_req = pin_low & ~ctrl.edge_mode;

  dbg_halt_flags i_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_fof (core_fof),
    .ev_trg (core_trg),
    .ev_hlt (core_halt),
    .ev_pin (bkpt_halt_req),
    .go     (go_cmd),
    .flags  (flags)
  );

  // control bits: core writes blocked by the lock, lock owned by host
  assign wr_take = csr_wr & (csr_host | ~ctrl.wr_lock);
  assign ctrl_wv = ctrl_t'(csr_wdata[CTRL_LSB +: CTRL_W]);

  always_comb begin
    ctrl_nxt = ctrl_wv;
    if (!csr_host) ctrl_nxt.wr_lock = ctrl.wr_lock;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_take) ctrl <= ctrl_nxt;
  end

  assign csr_rdata = {status, flags, REV_CODE, 1'b0, ctrl, {CTRL_LSB{1'b0}}};

  assign trace_clk_en    = ~ctrl.trace_off;
  assign trace_valid_out = trace_valid_in & ~ctrl.trace_off;
  assign emu_map_space   = ctrl.map_space;
  assign emu_on_trace    = ctrl.emu_trace;
  assign emu_force       = ctrl.emu_force;

  AST_LOCK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_host && ctrl.wr_lock) |=> (ctrl == $past(ctrl))); // R11
  AST_CORE_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_host) |=> (ctrl.wr_lock == $past(ctrl.wr_lock))); // R11
  AST_EDGE_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.edge_mode |-> !bkpt_halt_req); // R8
endmodule

// File: tb/test_dbg_csr.sv
`timescale 1ns/1ps
module test_dbg_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 0, csr_rd = 0, csr_host = 0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        td_wr = 0, td_l1_en = 0, td_l2_en = 0, bp_l1_hit = 0, bp_l2_hit = 0;
  logic        core_fof = 0, core_trg = 0, core_halt = 0, go_cmd = 0;
  logic        bkpt_n = 1, inst_boundary = 0, trace_valid_in = 0;
  logic        bkpt_halt_req, dbg_irq, dbg_irq_pend, trace_clk_en, trace_valid_out;
  logic        emu_map_space, emu_on_trace, emu_force;

  int n_chk = 0;
  int n_fail = 0;
  localparam logic [31:0] BASE = 32'h0020_0000;

  always #2 clk = ~clk;

  dbg_csr i_dbg_csr (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_host(csr_host),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .td_wr(td_wr), .td_l1_en(td_l1_en),
    .td_l2_en(td_l2_en), .bp_l1_hit(bp_l1_hit), .bp_l2_hit(bp_l2_hit),
    .core_fof(core_fof), .core_trg(core_trg), .core_halt(core_halt), .go_cmd(go_cmd),
    .bkpt_n(bkpt_n), .inst_boundary(inst_boundary), .trace_valid_in(trace_valid_in),
    .bkpt_halt_req(bkpt_halt_req), .dbg_irq(dbg_irq), .dbg_irq_pend(dbg_irq_pend),
    .trace_clk_en(trace_clk_en), .trace_valid_out(trace_valid_out),
    .emu_map_space(emu_map_space), .emu_on_trace(emu_on_trace), .emu_force(emu_force)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic host_wr(input logic [31:0] d, input logic host);
    csr_wr = 1; csr_host = host; csr_wdata = d;
    step();
    csr_wr = 0; csr_host = 0; csr_wdata = '0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R13: reset state
    chk(csr_rdata == BASE, "R13 reset value", csr_rdata, BASE);
    chk({bkpt_halt_req, dbg_irq, dbg_irq_pend, trace_clk_en, trace_valid_out,
         emu_map_space, emu_on_trace, emu_force} == 8'b0001_0000, "R13 reset outputs",
        {24'd0, bkpt_halt_req, dbg_irq, dbg_irq_pend, trace_clk_en, trace_valid_out,
         emu_map_space, emu_on_trace, emu_force}, 32'h10);

    // R1 R2 R3: status sweep over level enables
    for (int l1 = 0; l1 < 2; l1++) begin
      for (int l2 = 0; l2 < 2; l2++) begin
        logic [3:0] e;
        do_reset();
        td_wr = 1; td_l1_en = l1[0]; td_l2_en = l2[0];
        step();
        td_wr = 0; td_l1_en = 0; td_l2_en = 0;
        e = l1 ? 4'h1 : 4'h0;
        chk(csr_rdata[31:28] == e, "R1 arm code", {28'd0, csr_rdata[31:28]}, {28'd0, e});
        bp_l2_hit = 1; step(); bp_l2_hit = 0;
        chk(csr_rdata[31:28] == e, "R2 early l2 ignored", {28'd0, csr_rdata[31:28]}, {28'd0, e});
        csr_rd = 1; step(); csr_rd = 0;
        chk(csr_rdata[31:28] == e, "R3 read while waiting", {28'd0, csr_rdata[31:28]}, {28'd0, e});
        bp_l1_hit = 1; step(); bp_l1_hit = 0;
        e = (l1 == 0) ? 4'h0 : (l2 != 0 ? 4'h5 : 4'h2);
        chk(csr_rdata[31:28] == e, "R2 l1 hit", {28'd0, csr_rdata[31:28]}, {28'd0, e});
        bp_l2_hit = 1; step(); bp_l2_hit = 0;
        if (e == 4'h5) e = 4'h6;
        chk(csr_rdata[31:28] == e, "R2 l2 hit", {28'd0, csr_rdata[31:28]}, {28'd0, e});
        csr_rd = 1;
        #1;
        chk(csr_rdata[31:28] == e, "R3 read returns pre-clear", {28'd0, csr_rdata[31:28]}, {28'd0, e});
        step(); csr_rd = 0;
        if (e == 4'h6 || e == 4'h2) e = 4'h0;
        chk(csr_rdata[31:28] == e, "R3 read clear", {28'd0, csr_rdata[31:28]}, {28'd0, e});
      end
    end

    // R3: read-clear collides with definition write
    do_reset();
    td_wr = 1; td_l1_en = 1; td_l2_en = 1; step(); td_wr = 0;
    bp_l1_hit = 1; step(); bp_l1_hit = 0;
    bp_l2_hit = 1; step(); bp_l2_hit = 0;
    csr_rd = 1; td_wr = 1; step(); csr_rd = 0; td_wr = 0; td_l1_en = 0; td_l2_en = 0;
    chk(csr_rdata[31:28] == 4'h1, "R3 write beats read clear", {28'd0, csr_rdata[31:28]}, 32'h1);

    // R4 R5: preset flags x same-cycle events x GO
    for (int pre = 0; pre < 8; pre++) begin
      for (int ev = 0; ev < 8; ev++) begin
        for (int g = 0; g < 2; g++) begin
          logic [2:0] ex;
          do_reset();
          core_fof = pre[2]; core_trg = pre[1]; core_halt = pre[0];
          step();
          core_fof = ev[2]; core_trg = ev[1]; core_halt = ev[0]; go_cmd = g[0];
          step();
          core_fof = 0; core_trg = 0; core_halt = 0; go_cmd = 0;
          ex[2] = pre[2] | ev[2];
          ex[1] = ev[1] | (pre[1] & (g == 0));
          ex[0] = ev[0] | (pre[0] & (g == 0));
          chk(csr_rdata[27:25] == ex, "R4 R5 flags vs GO", {29'd0, csr_rdata[27:25]}, {29'd0, ex});
        end
      end
    end
    // R4: fault flag survives GO
    go_cmd = 1; step(); go_cmd = 0;
    chk(csr_rdata[27] == 1'b1, "R4 fof survives GO", {31'd0, csr_rdata[27]}, 32'd1);

    // R6 R10 R11 R12: control sweep
    for (int v = 0; v < 64; v++) begin
      for (int h = 0; h < 2; h++) begin
        for (int lk = 0; lk < 2; lk++) begin
          logic [5:0] ex;
          logic [31:0] d;
          do_reset();
          if (lk != 0) host_wr(32'h0001_0000, 1'b1);
          d = ~(32'h3F << 13) | (32'(v) << 13);
          host_wr(d, h[0]);
          if (h != 0)       ex = v[5:0];
          else if (lk != 0) ex = 6'b001000;
          else              ex = v[5:0] & 6'b110111;
          chk(csr_rdata == (BASE | (32'(ex) << 13)), "R6 R11 R12 control write",
              csr_rdata, BASE | (32'(ex) << 13));
          chk({emu_map_space, emu_on_trace, emu_force} == ex[2:0], "R12 mode outputs",
              {29'd0, emu_map_space, emu_on_trace, emu_force}, {29'd0, ex[2:0]});
          trace_valid_in = 1;
          #1;
          chk({trace_clk_en, trace_valid_out} == {2{~ex[4]}}, "R10 trace gating",
              {30'd0, trace_clk_en, trace_valid_out}, {30'd0, {2{~ex[4]}}});
          trace_valid_in = 0;
        end
      end
    end

    // R7: level mode pin
    do_reset();
    bkpt_n = 0;
    step();
    chk(bkpt_halt_req == 0, "R7 halt req after one edge", {31'd0, bkpt_halt_req}, 32'd0);
    step();
    chk(bkpt_halt_req == 1, "R7 halt req after two edges", {31'd0, bkpt_halt_req}, 32'd1);
    chk(csr_rdata[24] == 0, "R7 flag not yet set", {31'd0, csr_rdata[24]}, 32'd0);
    step();
    chk(csr_rdata[24] == 1 && dbg_irq == 0, "R7 flag set, no irq", {30'd0, csr_rdata[24], dbg_irq}, 32'd2);
    bkpt_n = 1; step(); step(); step();
    go_cmd = 1; step(); go_cmd = 0;
    chk(csr_rdata[24] == 0, "R5 GO clears pin flag", {31'd0, csr_rdata[24]}, 32'd0);

    // R8 R9: edge mode pin
    do_reset();
    host_wr(32'h0004_0000, 1'b1);
    bkpt_n = 0;
    step(); step();
    chk(dbg_irq == 0 && bkpt_halt_req == 0, "R8 no irq before third edge", {30'd0, dbg_irq, bkpt_halt_req}, 32'd0);
    step();
    chk(dbg_irq == 1 && dbg_irq_pend == 1, "R8 irq on third edge", {30'd0, dbg_irq, dbg_irq_pend}, 32'd3);
    step();
    chk(dbg_irq == 0 && dbg_irq_pend == 1, "R8 one-cycle pulse, still pending", {30'd0, dbg_irq, dbg_irq_pend}, 32'd1);
    chk(csr_rdata[24] == 0 && bkpt_halt_req == 0, "R8 no halt in edge mode", {30'd0, csr_rdata[24], bkpt_halt_req}, 32'd0);
    bkpt_n = 1; step(); step(); step();
    bkpt_n = 0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        step();
        if (dbg_irq) seen++;
      end
      chk(seen == 0, "R9 edge dropped while pending", seen, 0);
    end
    inst_boundary = 1; step(); inst_boundary = 0;
    chk(dbg_irq_pend == 0, "R8 pending clears at boundary", {31'd0, dbg_irq_pend}, 32'd0);
    bkpt_n = 1; step(); step(); step();
    bkpt_n = 0; step(); step(); step();
    chk(dbg_irq == 1, "R8 new edge after service", {31'd0, dbg_irq}, 32'd1);
    bkpt_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule